// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products logic fabric. It takes a set of product-term signals and a static configuration word. It ORs together the terms that the configuration enables and can invert that sum. It then presents the result in one of three ways: directly, through an edge-triggered register, or through a level-sensitive latch. The storage element is timed by one of two global clocks. Two asynchronous inputs force the stored value low or high at any time, with no clock needed.

The cell's value goes out on a pin-driver output, which has its own enable. A separate feedback output always carries the same value back to the interconnect. The cell also returns the pin's level. When the driver is disabled, the pin can therefore act as an input while the cell's storage stays buried and still feeds back internally.

Configuration word layout, for `NTERM` terms: bits `[NTERM-1:0]` enable one term each. Bits `[NTERM+1:NTERM]` select the mode. Bit `NTERM+2` inverts the sum. Bit `NTERM+3` selects the clock.

Top module: `mcell_top`

## Requirements
- R1: The sum is the OR of every term whose enable bit `cfg[i]` is 1. Terms whose enable is 0 have no effect, and with no term enabled the sum is 0.
- R2: When `cfg[NTERM+2]` is 1, the sum is inverted before storage and before the direct path. With no term enabled and inversion on, the cell value is a constant 1.
- R3: Mode codes 2'b00 and 2'b11 in `cfg[NTERM+1:NTERM]` select the direct path. The cell value then follows the polarity-adjusted sum with no clock involved.
- R4: Mode code 2'b01 selects the register. The cell value takes the polarity-adjusted sum on each rising edge of the selected clock and holds it between edges.
- R5: `cfg[NTERM+3]` = 0 selects `clk_a` and 1 selects `clk_b` as the storage clock. Edges on the clock that is not selected do not change the stored value.
- R6: Mode code 2'b10 selects the latch. The cell value follows the sum while the selected clock is high and holds the last value while it is low.
- R7: `clr` high forces the stored value to 0 at once, with no clock. `pre` high with `clr` low forces it to 1 at once. When both are high, the value is 0. After a force is released, the forced value is held until the next capture.
- R8: `fb` carries the cell value in every mode, whatever the level of `oe`.
- R9: `pad_oe` equals `oe` and `pad_o` carries the cell value. `pin_val` equals `pad_i` while `oe` is 0 and equals the cell value while `oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First global clock |
| clk_b | input | 1 | Second global clock |
| clr | input | 1 | Asynchronous force-to-0, active high, highest priority |
| pre | input | 1 | Asynchronous force-to-1, active high |
| cfg | input | NTERM+4 | Static configuration: term enables, mode, invert, clock select |
| terms | input | NTERM | Product-term inputs |
| oe | input | 1 | Pin driver enable |
| pad_i | input | 1 | Level seen on the pin |
| fb | output | 1 | Feedback value to the interconnect |
| pad_o | output | 1 | Value to drive on the pin |
| pad_oe | output | 1 | Pin driver enable out |
| pin_val | output | 1 | Pin value returned to the interconnect |

## Verification
The bench builds the cell with the default `NTERM` of 16. This makes the full enable mask reachable, so both the empty mask and disabled terms that carry ones can be driven. The second clock has twice the period of the first and is offset from it. As a result, register and latch captures on the unselected clock fall in windows where they can be told apart from captures on the selected one. Clock-select changes are made while the other fields stay still. The mode, polarity, forces and pin enable are mixed at random against a bench model that follows both clocks.

// File: rtl/mcell_pkg.sv
`timescale 1ns/100ps
package mcell_pkg;

  // Cell operating mode, taken from two configuration bits.
  typedef enum logic [1:0] {
    MC_PASS     = 2'b00,
    MC_REG      = 2'b01,
    MC_LATCH    = 2'b10,
    MC_PASS_ALT = 2'b11
  } mc_mode_e;

  // Control bits above the term enables: mode (2), invert (1), clock select (1).
  localparam int MC_CTRL_W = 4;

  function automatic logic mc_uses_store(input mc_mode_e m);
    return (m == MC_REG) || (m == MC_LATCH);
  endfunction

  function automatic logic mc_is_latch(input mc_mode_e m);
    return m == MC_LATCH;
  endfunction

endpackage

// File: rtl/mcell_sum.sv
`timescale 1ns/100ps
module mcell_sum #(
  parameter int NTERM = 16
) (
  input  logic [NTERM-1:0] terms,
  input  logic [NTERM-1:0] term_en,
  input  logic             invert,
  output logic             sum_pol
);

  logic [NTERM-1:0] gated;

  // One gate per term: a disabled term never reaches the OR.
  for (genvar g = 0; g < NTERM; g++) begin : g_term
    assign gated[g] = terms[g] & term_en[g];
  end

  function automatic logic or_all(input logic [NTERM-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NTERM; i++) acc = acc | v[i];
    return acc;
  endfunction

  function automatic logic apply_pol(input logic s, input logic inv);
    return s ^ inv;
  endfunction

  assign sum_pol = apply_pol(or_all(gated), invert);

endmodule

// File: rtl/mcell_store.sv
`timescale 1ns/100ps
module mcell_store
  import mcell_pkg::*;
(
  input  logic     clk_a,
  input  logic     clk_b,
  input  logic     clk_sel,
  input  mc_mode_e mode,
  input  logic     d,
  input  logic     clr,
  input  logic     pre,
  output logic     sclk,
  output logic     store_q
);

  logic reg_q;
  logic lat_q;

  // Static selection between the two global clocks.
  assign sclk = clk_sel ? clk_b : clk_a;

  // Edge-triggered element, forces take effect without a clock.
  always_ff @(posedge sclk or posedge clr or posedge pre) begin
    if (clr)      reg_q <= 1'b0;
    else if (pre) reg_q <= 1'b1;
    else          reg_q <= d;
  end

  // Level-sensitive element, open while the selected clock is high.
  always_latch begin
    if (clr)       lat_q <= 1'b0;
    else if (pre)  lat_q <= 1'b1;
    else if (sclk) lat_q <= d;
  end

  assign store_q = mc_is_latch(mode) ? lat_q : reg_q;

endmodule

// File: rtl/mcell_route.sv
`timescale 1ns/100ps
module mcell_route
  import mcell_pkg::*;
(
  input  mc_mode_e mode,
  input  logic     sum_pol,
  input  logic     store_q,
  input  logic     oe,
  input  logic     pad_i,
  output logic     fb,
  output logic     pad_o,
  output logic     pad_oe,
  output logic     pin_val
);

  logic cell_val;

  assign cell_val = mc_uses_store(mode) ? store_q : sum_pol;

  // Feedback never depends on the pin driver state.
  assign fb      = cell_val;
  assign pad_o   = cell_val;
  assign pad_oe  = oe;
  assign pin_val = oe ? cell_val : pad_i;

endmodule

// File: rtl/mcell_top.sv
`timescale 1ns/100ps
module mcell_top
  import mcell_pkg::*;
#(
  parameter  int NTERM = 16,
  localparam int CFG_W = NTERM + MC_CTRL_W
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             clr,
  input  logic             pre,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NTERM-1:0] terms,
  input  logic             oe,
  input  logic             pad_i,
  output logic             fb,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             pin_val
);

  localparam int MODE_LO = NTERM;
  localparam int INV_BIT = NTERM + 2;
  localparam int SEL_BIT = NTERM + 3;

  logic [NTERM-1:0] term_en_w;
  mc_mode_e         mode_w;
  logic             inv_w;
  logic             csel_w;
  logic             sum_pol_w;
  logic             sclk_w;
  logic             store_w;

  assign term_en_w = cfg[NTERM-1:0];
  assign mode_w    = mc_mode_e'(cfg[MODE_LO+1:MODE_LO]);
  assign inv_w     = cfg[INV_BIT];
  assign csel_w    = cfg[SEL_BIT];

  mcell_sum #(.NTERM(NTERM)) u_sum (
    .terms   (terms),
    .term_en (term_en_w),
    .invert  (inv_w),
    .sum_pol (sum_pol_w)
  );

  mcell_store u_store (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .clk_sel (csel_w),
    .mode    (mode_w),
    .d       (sum_pol_w),
    .clr     (clr),
    .pre     (pre),
    .sclk    (sclk_w),
    .store_q (store_w)
  );

  mcell_route u_route (
    .mode    (mode_w),
    .sum_pol (sum_pol_w),
    .store_q (store_w),
    .oe      (oe),
    .pad_i   (pad_i),
    .fb      (fb),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe),
    .pin_val (pin_val)
  );

endmodule

// File: rtl/mcell_checker.sv
`timescale 1ns/100ps
module mcell_checker
  import mcell_pkg::*;
(
  input logic       clk_a,
  input logic       clr,
  input logic       pre,
  input logic       sclk,
  input logic [1:0] mode,
  input logic       d,
  input logic       store_q,
  input logic       fb,
  input logic       oe,
  input logic       pad_i,
  input logic       pin_val,
  input logic       pad_o,
  input logic       pad_oe
);

  // Set when a force occurred since the last storage clock edge.
  logic ovr_seen;
  always_ff @(posedge sclk or posedge clr or posedge pre) begin
    if (clr || pre) ovr_seen <= 1'b1;
    else            ovr_seen <= 1'b0;
  end

  // R4: register takes the sum sampled at the previous edge
  a_r4_reg_capture: assert property (@(posedge sclk) disable iff (clr || pre)
    (mode == MC_REG) |=> ((mode != MC_REG) || ovr_seen || (store_q == $past(d))));

  // R6: latch is transparent right up to its closing edge
  a_r6_latch_open: assert property (@(negedge sclk) disable iff (clr || pre)
    (mode == MC_LATCH) |-> (store_q == d));

  // R3: direct path follows the sum
  a_r3_pass_follow: assert property (@(posedge clk_a) disable iff (clr)
    ((mode == MC_PASS) || (mode == MC_PASS_ALT)) |-> (fb == d));

  // R9: pin return and driver
  a_r9_pin_input: assert property (@(posedge clk_a) disable iff (clr)
    !oe |-> (pin_val == pad_i));
  a_r9_pin_drive: assert property (@(posedge clk_a) disable iff (clr)
    oe |-> ((pin_val == fb) && (pad_o == fb) && pad_oe));

  // R7: forces act without a clock, clear wins
  always @(negedge clk_a) begin
    if (clr) begin
      a_r7_clr_wins: assert (store_q == 1'b0);
    end else if (pre) begin
      a_r7_pre_sets: assert (store_q == 1'b1);
    end
  end

endmodule

bind mcell_top mcell_checker u_mcell_chk (
  .clk_a   (clk_a),
  .clr     (clr),
  .pre     (pre),
  .sclk    (sclk_w),
  .mode    (mode_w),
  .d       (sum_pol_w),
  .store_q (store_w),
  .fb      (fb),
  .oe      (oe),
  .pad_i   (pad_i),
  .pin_val (pin_val),
  .pad_o   (pad_o),
  .pad_oe  (pad_oe)
);

// File: tb/test_mcell_top.sv
`timescale 1ns/100ps
module test_mcell_top;

  localparam int NT = 16;
  localparam int CW = NT + 4;

  logic          clk_a = 1'b0;
  logic          clk_b = 1'b0;
  logic          clr   = 1'b1;
  logic          pre   = 1'b0;
  logic [CW-1:0] cfg   = {1'b0, 1'b0, 2'b01, {NT{1'b0}}};
  logic [NT-1:0] terms = '0;
  logic          oe    = 1'b0;
  logic          pad_i = 1'b0;
  wire           fb, pad_o, pad_oe, pin_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk_a = ~clk_a;
  initial begin
    #1.25;
    forever begin
      clk_b = ~clk_b;
      #5;
    end
  end

  mcell_top #(.NTERM(NT)) i_mcell_top (
    .clk_a(clk_a), .clk_b(clk_b), .clr(clr), .pre(pre), .cfg(cfg),
    .terms(terms), .oe(oe), .pad_i(pad_i), .fb(fb), .pad_o(pad_o),
    .pad_oe(pad_oe), .pin_val(pin_val)
  );

  // ---------------- bench model ----------------
  function automatic logic [CW-1:0] mk_cfg(input logic [NT-1:0] en, input logic [1:0] md,
                                           input logic inv, input logic sel);
    return {sel, inv, md, en};
  endfunction

  function automatic logic b_sum(input logic [CW-1:0] c, input logic [NT-1:0] t);
    int hits;
    hits = 0;
    for (int i = 0; i < NT; i++) if (c[i] && t[i]) hits++;
    return (hits > 0) ? !c[NT+2] : c[NT+2];
  endfunction

  wire b_sclk = cfg[NT+3] ? clk_b : clk_a;
  logic m_q = 1'b0;
  logic m_l = 1'b0;

  always @(posedge b_sclk) begin
    if (clr)      m_q = 1'b0;
    else if (pre) m_q = 1'b1;
    else          m_q = b_sum(cfg, terms);
  end
  always @(negedge b_sclk) begin
    if (clr)      m_l = 1'b0;
    else if (pre) m_l = 1'b1;
    else          m_l = b_sum(cfg, terms);
  end
  always @(posedge clr) begin
    m_q = 1'b0;
    m_l = 1'b0;
  end
  always @(posedge pre) if (!clr) begin
    m_q = 1'b1;
    m_l = 1'b1;
  end

  function automatic logic exp_val();
    logic d;
    d = b_sum(cfg, terms);
    case (cfg[NT+1:NT])
      2'b01:   return clr ? 1'b0 : (pre ? 1'b1 : m_q);
      2'b10:   return clr ? 1'b0 : (pre ? 1'b1 : (b_sclk ? d : m_l));
      default: return d;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    logic ev;
    string tag;
    ev = exp_val();
    case (cfg[NT+1:NT])
      2'b01:   tag = "R4 register value";
      2'b10:   tag = "R6 latch value";
      default: tag = "R3 direct value";
    endcase
    if (clr || pre) tag = "R7 forced value";
    chk(tag, fb, ev);
    chk("R8 feedback vs pin", pad_o, fb);
    chk("R9 pin return", pin_val, oe ? ev : pad_i);
    chk("R9 driver enable", pad_oe, oe);
  endtask

  // Clock select first, other fields after, so a select glitch sees stable data.
  task automatic drive_cfg(input logic [CW-1:0] c);
    cfg[NT+3] = c[NT+3];
    #0.1;
    cfg = c;
  endtask

  task automatic rand_step();
    logic [31:0] r;
    logic [NT-1:0] en;
    r = $urandom;
    @(posedge clk_a);
    #0.6;
    en = (r[7:4] == 4'd0) ? '0 : NT'($urandom);
    if (r[15:13] == 3'd0) drive_cfg(mk_cfg(en, r[1:0], r[3], r[2]));
    else #0.1;
    terms = NT'($urandom);
    oe    = r[8];
    pad_i = r[9];
    case (r[12:10])
      3'd0: clr = 1'b1;
      3'd1: pre = 1'b1;
      3'd2: begin clr = 1'b1; pre = 1'b1; end
      default: ;
    endcase
    #0.9;
    chk_model();
    pre = 1'b0;
    #0.1;
    clr = 1'b0;
    #0.3;
    chk_model();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd5821));

    // Reset state: clear held, register mode, driver off (R7, R9)
    repeat (4) @(posedge clk_a);
    #0.6;
    chk("R7 reset value", fb, 1'b0);
    chk("R9 reset driver", pad_oe, 1'b0);
    #0.1 clr = 1'b0;

    // Sum and polarity on the direct path (R1, R2, R3)
    drive_cfg(mk_cfg(16'h00F0, 2'b00, 1'b0, 1'b0));
    terms = 16'h0010; #0.3 chk("R1 enabled term", fb, 1'b1);
    terms = 16'h000F; #0.3 chk("R1 disabled terms ignored", fb, 1'b0);
    cfg = mk_cfg(16'h00F0, 2'b00, 1'b1, 1'b0); #0.3 chk("R2 inverted sum", fb, 1'b1);
    cfg = mk_cfg(16'h0000, 2'b00, 1'b0, 1'b0); terms = 16'hFFFF;
    #0.3 chk("R1 no term enabled", fb, 1'b0);
    cfg = mk_cfg(16'h0000, 2'b00, 1'b1, 1'b0); #0.3 chk("R2 empty sum inverted", fb, 1'b1);
    cfg = mk_cfg(16'h8000, 2'b11, 1'b0, 1'b0); terms = 16'h8000;
    #0.3 chk("R3 alternate direct code", fb, 1'b1);
    terms = 16'h0000; #0.3 chk("R3 alternate direct code", fb, 1'b0);

    // Clock selection (R5, R4)
    drive_cfg(mk_cfg(16'h0001, 2'b01, 1'b0, 1'b1));
    @(negedge clk_a); #0.3 clr = 1'b1; #0.2 clr = 1'b0;
    @(negedge clk_b); #0.2 terms = 16'h0001;
    @(posedge clk_a); #0.3 chk("R5 unselected clock ignored", fb, 1'b0);
    @(posedge clk_b); #0.3 chk("R5 selected clock captures", fb, 1'b1);
    drive_cfg(mk_cfg(16'h0001, 2'b01, 1'b0, 1'b0));
    @(negedge clk_a); #0.3 terms = 16'h0000;
    #0.3 chk("R4 holds between edges", fb, 1'b1);
    @(posedge clk_a); #0.3 chk("R4 captures on edge", fb, 1'b0);

    // Latch mode (R6)
    drive_cfg(mk_cfg(16'h0001, 2'b10, 1'b0, 1'b0));
    @(posedge clk_a); #0.3 terms = 16'h0001;
    #0.3 chk("R6 open follows", fb, 1'b1);
    terms = 16'h0000; #0.3 chk("R6 open follows", fb, 1'b0);
    terms = 16'h0001; #0.3 chk("R6 open follows", fb, 1'b1);
    @(negedge clk_a); #0.3 terms = 16'h0000;
    #0.3 chk("R6 closed holds", fb, 1'b1);
    @(posedge clk_a); #0.3 chk("R6 reopens", fb, 1'b0);

    // Asynchronous forces (R7)
    drive_cfg(mk_cfg(16'h0001, 2'b01, 1'b0, 1'b0));
    terms = 16'h0000;
    @(posedge clk_a); #0.3 chk("R4 stored zero", fb, 1'b0);
    @(negedge clk_a); #0.3 pre = 1'b1;
    #0.3 chk("R7 preset without clock", fb, 1'b1);
    pre = 1'b0; #0.3 chk("R7 preset value held", fb, 1'b1);
    clr = 1'b1; #0.3 chk("R7 clear without clock", fb, 1'b0);
    pre = 1'b1; #0.3 chk("R7 clear wins over preset", fb, 1'b0);
    pre = 1'b0; #0.1 clr = 1'b0;
    #0.3 chk("R7 cleared value held", fb, 1'b0);

    // Pin and feedback (R8, R9)
    cfg = mk_cfg(16'h0001, 2'b00, 1'b0, 1'b0);
    terms = 16'h0000; oe = 1'b0; pad_i = 1'b1;
    #0.3 chk("R9 pin as input", pin_val, 1'b1);
    chk("R8 feedback with driver off", fb, 1'b0);
    chk("R9 driver off", pad_oe, 1'b0);
    oe = 1'b1;
    #0.3 chk("R9 pin driven", pin_val, 1'b0);
    chk("R9 pad value", pad_o, 1'b0);
    chk("R9 driver on", pad_oe, 1'b1);
    terms = 16'h0001; oe = 1'b0;
    #0.3 chk("R8 feedback with driver off", fb, 1'b1);
    chk("R9 pin as input", pin_val, 1'b1);
    pad_i = 1'b0;
    #0.3 chk("R9 pin as input", pin_val, 1'b0);

    // Random mix against the model
    for (int n = 0; n < 600; n++) rand_step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule